// File: doc/BRIEF.md
# FEC Encoder Framing Controller

This block sits in a 64-bit pipelined data path and turns one payload into four protected fragments when it is armed. A write of the payload byte count to the length register arms it for the next transfer. The controller then takes in exactly the words that make up that payload. It splits the payload at a byte boundary into a first half of ceil(len/2) bytes and a second half with the remainder. Each half is zero-padded to the same whole number of 8-byte words.

It then emits four fragments in order: the two data halves, then two parity fragments. Each fragment starts with a header beat. Every beat carries 8 data bytes plus one check byte, so a fragment is 9 bytes of header plus 9 bytes for every 8 padded bytes. With a 1500-byte payload, each half pads to 752 bytes and each fragment is 855 bytes. The parity arithmetic is a simple XOR stub.

While the controller is not armed, it is transparent: words and stall pass straight through. The armed state clears by itself after the last beat of the fourth fragment.

Top module: `fec_frame_ctrl`

## Requirements
- R1: After reset the block is disarmed and in passthrough, and the sequence number carried by the first encoded frame is 0.
- R2: While disarmed, out_valid equals in_valid, out_data equals in_data, out_chk is 0 and in_stall equals out_stall.
- R3: A cfg_wr while disarmed, with cfg_len from 1 to MAX_LEN, arms the block. A length of 0 or above MAX_LEN is ignored, and any cfg_wr while armed is ignored.
- R4: Once armed, the block accepts ceil(len/8) input words with in_stall low and out_valid low. Payload byte n is byte n%8 (bits 8*(n%8)+7 down to 8*(n%8)) of word n/8. Bytes at or beyond len are discarded.
- R5: The block then outputs four fragments, indexed 0 to 3 in order. Each fragment is 1 + W beats, where W = ceil(H/8) and H = ceil(len/2). in_stall stays high throughout.
- R6: Beat 0 of each fragment is a header with the following layout. Bits 7:0 hold the fragment index. Bits 23:8 hold len. Bits 39:24 hold the frame sequence number. Bits 63:40 hold the constant 0x5AF0EC.
- R7: In data beat k (1 to W), fragment 0 byte j is payload byte 8(k-1)+j when that index is below H, otherwise 0. Fragment 1 byte j is payload byte H+8(k-1)+j when 8(k-1)+j is below len-H, otherwise 0.
- R8: In the same beat, fragment 2 is the XOR of the fragment 0 and fragment 1 words. Fragment 3 is the fragment 0 word XOR the fragment 1 word rotated left by one byte ({w[55:0], w[63:56]}).
- R9: While armed, out_chk on every beat is the XOR of the eight bytes of out_data.
- R10: While armed and emitting, a beat held by out_stall keeps out_valid high, and out_data and out_chk stay unchanged until the beat is accepted.
- R11: After the last beat of fragment 3 is accepted, the block disarms, returns to passthrough, and increments the sequence number by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Length register write strobe |
| cfg_len | input | 16 | Payload byte count to write |
| in_valid | input | 1 | Input word valid |
| in_data | input | 64 | Input word |
| in_stall | output | 1 | Input stall back-pressure |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 64 | Output word |
| out_chk | output | 8 | Check byte of the output beat |
| out_stall | input | 1 | Output stall from downstream |

## Verification
The assertions check, on every cycle, the following properties. A stalled beat stays frozen. The beat counter never overruns the fragment length. The length register holds while the block is armed. Disarming happens only right after the final beat of fragment 3 is accepted, and it steps the sequence number by one. The byte contents depend on the length, so only the bench's scenarios can show them: the split point, the zero padding of odd and short lengths, the masking of bytes beyond the length, the parity fragments, the check bytes and the header fields. The bench also shows that illegal or mid-frame length writes are rejected and that passthrough resumes.

// File: rtl/fec_frame_ctrl.sv
module fec_frame_ctrl #(
  parameter int          MAX_LEN = 1500,
  parameter logic [23:0] HDR_TAG = 24'h5AF0EC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [15:0] cfg_len,
  input  logic        in_valid,
  input  logic [63:0] in_data,
  output logic        in_stall,
  output logic        out_valid,
  output logic [63:0] out_data,
  output logic [7:0]  out_chk,
  input  logic        out_stall
);
  localparam int MEM_W = (MAX_LEN + 7) / 8;
  localparam int AW    = $clog2(MEM_W + 1);

  typedef enum logic [1:0] {IDLE, LOAD, EMIT} st_t;
  st_t         st;
  logic [15:0] len_q, seq_q, wcnt, bcnt;
  logic [1:0]  frag;
  logic [63:0] mem [MEM_W];

  wire         armed = (st != IDLE);
  wire  [15:0] h0    = (len_q + 16'd1) >> 1;
  wire  [15:0] h1    = len_q - h0;
  wire  [15:0] nw    = (len_q + 16'd7) >> 3;
  wire  [15:0] nbeat = (h0 + 16'd7) >> 3;
  wire  [15:0] base  = (bcnt - 16'd1) << 3;
  wire         len_ok = (cfg_len != 16'd0) && (cfg_len <= 16'(MAX_LEN));

  always_ff @(posedge clk)
    if (st == LOAD && in_valid) mem[wcnt[AW-1:0]] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; len_q <= '0; seq_q <= '0; wcnt <= '0; bcnt <= '0; frag <= '0;
    end else begin
      case (st)
        IDLE: if (cfg_wr && len_ok) begin
          len_q <= cfg_len; wcnt <= '0; st <= LOAD;
        end
        LOAD: if (in_valid) begin
          if (wcnt == nw - 16'd1) begin
            st <= EMIT; bcnt <= '0; frag <= '0;
          end else wcnt <= wcnt + 16'd1;
        end
        EMIT: if (!out_stall) begin
          if (bcnt == nbeat) begin
            bcnt <= '0;
            if (frag == 2'd3) begin
              st <= IDLE; seq_q <= seq_q + 16'd1;
            end else frag <= frag + 2'd1;
          end else bcnt <= bcnt + 16'd1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  logic [63:0] w0, w1, enc;
  logic [15:0] i0, i1;
  always_comb begin
    w0 = '0; w1 = '0;
    for (int j = 0; j < 8; j++) begin
      i0 = base + 16'(j);
      i1 = h0 + i0;
      if (i0 < h0) w0[8*j +: 8] = mem[i0[AW+2:3]][8*i0[2:0] +: 8];
      if (i0 < h1) w1[8*j +: 8] = mem[i1[AW+2:3]][8*i1[2:0] +: 8];
    end
    case (frag)
      2'd0:    enc = w0;
      2'd1:    enc = w1;
      2'd2:    enc = w0 ^ w1;
      default: enc = w0 ^ {w1[55:0], w1[63:56]};
    endcase
    if (bcnt == 16'd0) enc = {HDR_TAG, seq_q, len_q, 6'd0, frag};
  end

  logic [7:0] par;
  always_comb begin
    par = '0;
    for (int j = 0; j < 8; j++) par = par ^ enc[8*j +: 8];
  end

  assign out_valid = armed ? (st == EMIT) : in_valid;
  assign in_stall  = armed ? (st == EMIT) : out_stall;
  assign out_data  = armed ? enc : in_data;
  assign out_chk   = armed ? par : 8'd0;

  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (st == EMIT && out_stall) |=> (out_valid && $stable(out_data) && $stable(out_chk)));
  a_r5_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == EMIT) |-> (bcnt <= nbeat));
  a_r3_len_locked: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> (armed -> $stable(len_q)));
  a_r11_disarm_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> $past(frag == 2'd3 && bcnt == nbeat && !out_stall));
  a_r11_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> (seq_q == $past(seq_q) + 16'd1));
endmodule

// File: tb/fec_frame_ctrl_tb_top.sv
module fec_frame_ctrl_tb_top;
  localparam int MAXL = 1500;
  localparam int NV = 10;
  localparam int VL [NV] = '{1, 7, 8, 9, 16, 17, 23, 100, 1499, 1500};
  localparam bit VS [NV] = '{0, 1, 0, 1, 0, 1, 0, 1, 1, 0};

  logic clk = 0, rst_n = 0, cfg_wr = 0, in_valid = 0, out_stall = 0;
  logic [15:0] cfg_len = 0;
  logic [63:0] in_data = 0;
  logic in_stall, out_valid;
  logic [63:0] out_data;
  logic [7:0] out_chk;
  int checks = 0, fails = 0, seq = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fec_frame_ctrl #(.MAX_LEN(MAXL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_len(cfg_len),
    .in_valid(in_valid), .in_data(in_data), .in_stall(in_stall),
    .out_valid(out_valid), .out_data(out_data), .out_chk(out_chk),
    .out_stall(out_stall));

  function automatic logic [7:0] pb(int n);
    return 8'((n * 37 + 11) ^ (n >> 5));
  endfunction

  function automatic logic [71:0] exp_beat(int len, int sq, int f, int b);
    int h0, h1, k;
    logic [63:0] w0, w1, e;
    logic [7:0] c;
    h0 = (len + 1) / 2; h1 = len - h0;
    if (b == 0) e = {24'h5AF0EC, 16'(sq), 16'(len), 8'(f)};
    else begin
      k = 8 * (b - 1);
      w0 = '0; w1 = '0;
      for (int j = 0; j < 8; j++) begin
        if (k + j < h0) w0[8*j +: 8] = pb(k + j);
        if (k + j < h1) w1[8*j +: 8] = pb(h0 + k + j);
      end
      case (f)
        0: e = w0;
        1: e = w1;
        2: e = w0 ^ w1;
        default: e = w0 ^ {w1[55:0], w1[63:56]};
      endcase
    end
    c = '0;
    for (int j = 0; j < 8; j++) c = c ^ e[8*j +: 8];
    return {e, c};
  endfunction

  task automatic check(bit ok, string req, logic [71:0] act, logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic bypass_check(string req, logic [63:0] d);
    in_valid = 1; in_data = d; out_stall = 0; #1;
    check(out_valid && out_data == d && out_chk == 0 && !in_stall, req,
          {out_valid, out_data, out_chk}, {1'b1, d, 8'd0});
    out_stall = 1; #1;
    check(in_stall == 1, req, 72'(in_stall), 72'd1);
    tick; in_valid = 0; out_stall = 0;
  endtask

  task automatic run_frame(int len, bit stl, bit midwr);
    int nw, nb, f, b, cyc;
    logic [63:0] w;
    logic [71:0] e;
    bit ok_in, ok_out;
    cfg_wr = 1; cfg_len = 16'(len); tick; cfg_wr = 0;
    nw = (len + 7) / 8;
    ok_in = 1;
    for (int i = 0; i < nw; i++) begin
      for (int j = 0; j < 8; j++) w[8*j +: 8] = (8*i + j < len) ? pb(8*i + j) : 8'hEE;
      in_valid = 1; in_data = w;
      if (midwr && i == 0) begin cfg_wr = 1; cfg_len = 16'd999; end
      #1;
      if (in_stall || out_valid) ok_in = 0;
      tick; cfg_wr = 0;
    end
    in_valid = 0;
    check(ok_in, "R4 load without stall or output", 72'(ok_in), 72'd1);
    nb = 1 + ((len + 1) / 2 + 7) / 8;
    f = 0; b = 0; cyc = 0; ok_out = 1;
    while (f < 4) begin
      out_stall = stl && (cyc % 3 == 1);
      #1;
      e = exp_beat(len, seq, f, b);
      if (!out_valid || !in_stall || {out_data, out_chk} != e) begin
        if (ok_out)
          check(0, out_stall ? "R10 stalled beat" : "R5-R9 beat content",
                {out_data, out_chk}, e);
        ok_out = 0;
      end
      tick; cyc++;
      if (!out_stall) begin
        b++;
        if (b == nb) begin b = 0; f++; end
      end
      if (cyc > 4000) f = 4;
    end
    out_stall = 0;
    check(ok_out, "R5 R6 R7 R8 R9 R10 fragments", 72'(ok_out), 72'd1);
    seq++;
    bypass_check("R11 passthrough after frame", 64'hC0FFEE00 + 64'(len));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    bypass_check("R1 reset passthrough", 64'h0123456789ABCDEF);
    bypass_check("R2 passthrough", 64'hFEDCBA9876543210);
    cfg_wr = 1; cfg_len = 0; tick; cfg_wr = 0;
    bypass_check("R3 zero length ignored", 64'h1111);
    cfg_wr = 1; cfg_len = 16'(MAXL + 1); tick; cfg_wr = 0;
    bypass_check("R3 oversize length ignored", 64'h2222);
    for (int v = 0; v < NV; v++) run_frame(VL[v], VS[v], 0);
    run_frame(10, 1, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule